// File: doc/BRIEF.md
# Power-Down Entry and Staged Release Sequencer

This block sits between a group of functional inputs and the logic that consumes them, and manages a power-down state that one active-high request pin controls. While the block is active, the data inputs, the output-enable and the register clock-enable pass through a register stage to the consumers. When the request pin goes high, the captured values freeze at once. If the pin then stays high long enough to qualify, the block enters standby and drops four valid flags. Nothing on the functional inputs reaches the consumers while the block is in standby. The request pin is never one of the functional inputs.

When the pin goes low and stays low long enough to qualify, the block starts a release sequence. The captured inputs are released first, then the output-enable, then the clock-enable, and the outputs-valid flag comes last. Each stage has its own delay, set as a cycle count. Pulses on the request pin that are shorter than the minimum high or low width are filtered out and do not change state. A system integrator sets the widths and delays through parameters. The defaults keep the stage delays in the ratio 12:16:18:24, with a 12-cycle minimum high width and a 25-cycle minimum low width.

Top module: `pd_sequencer`

## Requirements
- R1: After reset the block is active: all four valid flags are 1, and the latched data, output-enable and clock-enable outputs are 0.
- R2: While active with the request pin low, each latched output takes the value its input had at the previous rising clock edge.
- R3: While active or qualifying entry, a rising clock edge that samples the request pin high loads nothing: the latched outputs keep the values sampled at the last edge where the pin was low. They also stay unchanged for as long as the input-valid flag is 0.
- R4: A high pulse that lasts fewer than HIGH_MIN consecutive sampled cycles leaves all flags at 1. The latched outputs follow their inputs again from the first edge that samples the pin low.
- R5: On the edge that samples the pin high for the HIGH_MIN-th consecutive time, all four valid flags go to 0.
- R6: In standby, a low pulse that lasts fewer than LOW_MIN consecutive sampled cycles raises no flag and leaves the latched outputs frozen.
- R7: Let L be the edge that samples the pin low for the LOW_MIN-th consecutive time. The input, output-enable, clock-enable and outputs-valid flags rise on edges L+DLY_IN, L+DLY_OE, L+DLY_CLK and L+DLY_OUT. A later flag is never 1 while an earlier one is 0.
- R8: During release, a latched output loads from its input only on edges at which its own flag was already 1 before the edge.
- R9: Once the release sequence has started, the request pin has no effect on the flags or on loading until the block is active again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_pin | input | 1 | Power-down request, active high |
| data_in | input | W | Functional data inputs |
| oe_in | input | 1 | Output-enable input |
| ce_in | input | 1 | Register clock-enable input |
| data_q | output | W | Latched data inputs |
| oe_q | output | 1 | Latched output-enable |
| ce_q | output | 1 | Latched clock-enable |
| in_valid | output | 1 | Latched data inputs are valid |
| oe_valid | output | 1 | Latched output-enable is valid |
| ce_valid | output | 1 | Latched clock-enable is valid |
| out_valid | output | 1 | Outputs are valid again |

## Verification
The hardest case to reach is a request-pin bump that arrives during the release sequence. It must be ignored there, yet the same level would abort wake-up one phase earlier. The stimulus first drives a full qualified entry and then a qualified wake. It raises the pin for three cycles only after the input flag has risen, and lowers it again before the outputs-valid edge. Throughout, fresh values change on every input in every cycle, so that each stage's exact first load edge becomes visible.

// File: rtl/pds_pkg.sv
// Shared types for the power-down sequencer.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable constructs.
package pds_pkg;

    typedef enum logic [2:0] {
        PDS_ACTIVE,
        PDS_ENTER_QUAL,
        PDS_STANDBY,
        PDS_WAKE_QUAL,
        PDS_RELEASE
    } pds_state_e;

    // Larger of two counts, used to size the shared counter.
    function automatic int pds_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pds_ctrl.sv
// Controller: filters the request pin by its minimum widths and walks
// active -> entry qualify -> standby -> wake qualify -> release -> active.
// Assumes: HIGH_MIN, LOW_MIN >= 1; DLY_OUT fits in CW bits.
module pds_ctrl
    import pds_pkg::*;
#(
    parameter int HIGH_MIN = 12,
    parameter int LOW_MIN  = 25,
    parameter int DLY_OUT  = 24,
    parameter int CW       = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pd_pin,
    output pds_state_e    state_o,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] HI_LAST  = CW'(HIGH_MIN - 1);
    localparam logic [CW-1:0] LO_LAST  = CW'(LOW_MIN - 1);
    localparam logic [CW-1:0] REL_LAST = CW'(DLY_OUT);
    localparam logic [CW-1:0] ONE      = CW'(1);

    pds_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Next-state and counter decision for the current pin sample.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            PDS_ACTIVE: begin
                if (pd_pin) begin
                    state_d = (HIGH_MIN <= 1) ? PDS_STANDBY : PDS_ENTER_QUAL;
                    cnt_d   = (HIGH_MIN <= 1) ? '0 : ONE;
                end
            end
            PDS_ENTER_QUAL: begin
                if (!pd_pin) begin
                    state_d = PDS_ACTIVE;
                    cnt_d   = '0;
                end else if (cnt_q >= HI_LAST) begin
                    state_d = PDS_STANDBY;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q + ONE;
                end
            end
            PDS_STANDBY: begin
                if (!pd_pin) begin
                    state_d = (LOW_MIN <= 1) ? PDS_RELEASE : PDS_WAKE_QUAL;
                    cnt_d   = (LOW_MIN <= 1) ? '0 : ONE;
                end
            end
            PDS_WAKE_QUAL: begin
                if (pd_pin) begin
                    state_d = PDS_STANDBY;
                    cnt_d   = '0;
                end else if (cnt_q >= LO_LAST) begin
                    state_d = PDS_RELEASE;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q + ONE;
                end
            end
            PDS_RELEASE: begin
                if (cnt_q >= REL_LAST) begin
                    state_d = PDS_ACTIVE;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q + ONE;
                end
            end
            default: begin
                state_d = PDS_ACTIVE;
                cnt_d   = '0;
            end
        endcase
    end

    // State and counter registers with synchronous reset to active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PDS_ACTIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;

endmodule

// File: rtl/pds_release_decode.sv
// Decodes the four stage-valid flags from the controller state and the
// release counter. Flag order: 0 inputs, 1 output-enable, 2 clock-enable,
// 3 outputs. Assumes DLY_IN < DLY_OE < DLY_CLK < DLY_OUT.
module pds_release_decode
    import pds_pkg::*;
#(
    parameter int CW      = 5,
    parameter int DLY_IN  = 12,
    parameter int DLY_OE  = 16,
    parameter int DLY_CLK = 18,
    parameter int DLY_OUT = 24
) (
    input  pds_state_e    state_i,
    input  logic [CW-1:0] cnt_i,
    output logic [3:0]    flags_o,
    output logic          rel_phase_o
);

    localparam logic [3:0][CW-1:0] THR = {CW'(DLY_OUT), CW'(DLY_CLK),
                                          CW'(DLY_OE),  CW'(DLY_IN)};

    logic running;

    // Running means the block has not yet committed to standby.
    always_comb begin
        running     = (state_i == PDS_ACTIVE) || (state_i == PDS_ENTER_QUAL);
        rel_phase_o = (state_i == PDS_RELEASE);
    end

    for (genvar k = 0; k < 4; k++) begin : g_stage
        assign flags_o[k] = running || (rel_phase_o && (cnt_i >= THR[k]));
    end

endmodule

// File: rtl/pds_hold_reg.sv
// Loadable holding register for one latched signal group.
// Assumes: load is computed before the edge; reset clears to zero.
module pds_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture on load, otherwise hold the frozen value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/pd_sequencer.sv
// Top: power-down sequencer. It freezes the data, output-enable and
// clock-enable inputs on a power-down request, qualifies the request by
// minimum widths, and releases the stages in a fixed order on wake-up.
// Assumes: the inputs are synchronous to clk, and the delay parameters
// rise strictly from DLY_IN to DLY_OUT.
module pd_sequencer
    import pds_pkg::*;
#(
    parameter int W        = 8,
    parameter int HIGH_MIN = 12,
    parameter int LOW_MIN  = 25,
    parameter int DLY_IN   = 12,
    parameter int DLY_OE   = 16,
    parameter int DLY_CLK  = 18,
    parameter int DLY_OUT  = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pd_pin,
    input  logic [W-1:0] data_in,
    input  logic         oe_in,
    input  logic         ce_in,
    output logic [W-1:0] data_q,
    output logic         oe_q,
    output logic         ce_q,
    output logic         in_valid,
    output logic         oe_valid,
    output logic         ce_valid,
    output logic         out_valid
);

    localparam int CNT_MAX = pds_max(pds_max(HIGH_MIN, LOW_MIN), DLY_OUT);
    localparam int CW      = $clog2(CNT_MAX + 1);

    pds_state_e    state;
    logic [CW-1:0] cnt;
    logic [3:0]    flags;
    logic          rel_phase;
    logic          freeze;
    logic          ld_data, ld_oe, ld_ce;

    pds_ctrl #(
        .HIGH_MIN(HIGH_MIN), .LOW_MIN(LOW_MIN), .DLY_OUT(DLY_OUT), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin),
        .state_o(state), .cnt_o(cnt)
    );

    pds_release_decode #(
        .CW(CW), .DLY_IN(DLY_IN), .DLY_OE(DLY_OE),
        .DLY_CLK(DLY_CLK), .DLY_OUT(DLY_OUT)
    ) u_dec (
        .state_i(state), .cnt_i(cnt),
        .flags_o(flags), .rel_phase_o(rel_phase)
    );

    // Load enables: a stage loads while valid, unless a request freezes it.
    always_comb begin
        freeze  = pd_pin && !rel_phase;
        ld_data = flags[0] && !freeze;
        ld_oe   = flags[1] && !freeze;
        ld_ce   = flags[2] && !freeze;
    end

    pds_hold_reg #(.W(W)) u_data (
        .clk(clk), .rst_n(rst_n), .load(ld_data), .d(data_in), .q(data_q)
    );
    pds_hold_reg #(.W(1)) u_oe (
        .clk(clk), .rst_n(rst_n), .load(ld_oe), .d(oe_in), .q(oe_q)
    );
    pds_hold_reg #(.W(1)) u_ce (
        .clk(clk), .rst_n(rst_n), .load(ld_ce), .d(ce_in), .q(ce_q)
    );

    assign in_valid  = flags[0];
    assign oe_valid  = flags[1];
    assign ce_valid  = flags[2];
    assign out_valid = flags[3];

endmodule

// File: rtl/pd_sequencer_chk.sv
// Checker for pd_sequencer: flag ordering, freezing of latched outputs,
// and the minimum high width before standby is entered.
// Assumes: bound to every pd_sequencer instance via the bind below.
module pd_sequencer_chk #(
    parameter int W        = 8,
    parameter int HIGH_MIN = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pd_pin,
    input logic [W-1:0] data_q,
    input logic         in_valid,
    input logic         oe_valid,
    input logic         ce_valid,
    input logic         out_valid,
    input logic         rel_phase
);

    localparam int HW = $clog2(HIGH_MIN + 1) + 1;
    localparam logic [HW-1:0] HSAT = HW'(HIGH_MIN);

    logic [HW-1:0] hi_run;

    // Counts consecutive high samples of the request pin, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (pd_pin) begin
            hi_run <= (hi_run >= HSAT) ? HSAT : hi_run + HW'(1);
        end else begin
            hi_run <= '0;
        end
    end

    // R7: no later stage is valid while an earlier one is not.
    a_r7_oe_after_in: assert property (@(posedge clk) disable iff (!rst_n)
        oe_valid |-> in_valid);
    a_r7_ce_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
        ce_valid |-> oe_valid);
    a_r7_out_after_ce: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ce_valid);
    a_r7_out_rises_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(ce_valid));

    // R3: a request outside release freezes the data latch.
    a_r3_freeze_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_pin && in_valid && !rel_phase) |=> $stable(data_q));
    // R3: data latch holds while the input stage is not valid.
    a_r3_hold_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(data_q));

    // R5: standby only follows HIGH_MIN consecutive high samples.
    a_r5_entry_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_valid) |-> (hi_run >= HSAT));

endmodule

bind pd_sequencer pd_sequencer_chk #(.W(W), .HIGH_MIN(HIGH_MIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .data_q(data_q),
    .in_valid(in_valid), .oe_valid(oe_valid), .ce_valid(ce_valid),
    .out_valid(out_valid), .rel_phase(rel_phase)
);

// File: tb/test_pd_sequencer.sv
// Directed bench for pd_sequencer: one task for each scenario.
module test_pd_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int W    = 8;
    localparam int HMIN = 12;
    localparam int LMIN = 25;
    localparam int DIN  = 12;
    localparam int DOE  = 16;
    localparam int DCLK = 18;
    localparam int DOUT = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pd_pin = 1'b0;
    logic [W-1:0] data_in = '0;
    logic         oe_in = 1'b0;
    logic         ce_in = 1'b0;
    logic [W-1:0] data_q;
    logic         oe_q, ce_q, in_valid, oe_valid, ce_valid, out_valid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pd_sequencer #(
        .W(W), .HIGH_MIN(HMIN), .LOW_MIN(LMIN), .DLY_IN(DIN),
        .DLY_OE(DOE), .DLY_CLK(DCLK), .DLY_OUT(DOUT)
    ) i_pd_sequencer (
        .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .data_in(data_in),
        .oe_in(oe_in), .ce_in(ce_in), .data_q(data_q), .oe_q(oe_q),
        .ce_q(ce_q), .in_valid(in_valid), .oe_valid(oe_valid),
        .ce_valid(ce_valid), .out_valid(out_valid)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_flags(input string req, input logic [3:0] exp);
        chk(req, "flags {out,ce,oe,in}",
            {28'd0, out_valid, ce_valid, oe_valid, in_valid}, {28'd0, exp});
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_flags("R1", 4'hF);
        chk("R1", "data_q", {24'd0, data_q}, 32'd0);
        chk("R1", "oe_q/ce_q", {30'd0, oe_q, ce_q}, 32'd0);
    endtask

    // R2: pass-through tracking while active
    task automatic t_track();
        logic [W-1:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
        foreach (pats[i]) begin
            data_in = pats[i];
            oe_in   = pats[i][0];
            ce_in   = pats[i][1];
            @(negedge clk);
            chk("R2", "data_q", {24'd0, data_q}, {24'd0, pats[i]});
            chk("R2", "oe_q/ce_q", {30'd0, oe_q, ce_q},
                {30'd0, pats[i][0], pats[i][1]});
        end
    endtask

    // R4: short high pulse is filtered, tracking resumes
    task automatic t_short_high();
        data_in = 8'h5A; oe_in = 1'b1; ce_in = 1'b0;
        @(negedge clk);
        pd_pin = 1'b1;
        for (int n = 1; n < HMIN; n++) begin
            data_in = W'(n * 13);
            @(negedge clk);
            chk_flags("R4", 4'hF);
            chk("R4", "data_q frozen", {24'd0, data_q}, 32'h5A);
        end
        pd_pin = 1'b0;
        data_in = 8'hC3;
        @(negedge clk);
        chk_flags("R4", 4'hF);
        chk("R4", "data_q resumes", {24'd0, data_q}, 32'hC3);
    endtask

    // R5, R3: qualified entry drops all flags at the HMIN-th sample
    task automatic t_enter();
        data_in = 8'h96; oe_in = 1'b1; ce_in = 1'b1;
        @(negedge clk);
        pd_pin = 1'b1;
        for (int n = 1; n <= HMIN + 3; n++) begin
            data_in = W'(n * 29 + 1); oe_in = n[0]; ce_in = n[1];
            @(negedge clk);
            chk_flags("R5", (n < HMIN) ? 4'hF : 4'h0);
            chk("R3", "data_q frozen", {24'd0, data_q}, 32'h96);
            chk("R3", "oe_q/ce_q frozen", {30'd0, oe_q, ce_q}, 32'd3);
        end
    endtask

    // R6: short low pulse in standby raises nothing
    task automatic t_short_low();
        pd_pin = 1'b0;
        for (int n = 1; n < LMIN; n++) begin
            data_in = W'(n * 7); oe_in = ~n[0]; ce_in = n[0];
            @(negedge clk);
            chk_flags("R6", 4'h0);
            chk("R6", "data_q frozen", {24'd0, data_q}, 32'h96);
        end
        pd_pin = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk_flags("R6", 4'h0);
        end
        chk("R6", "oe_q/ce_q frozen", {30'd0, oe_q, ce_q}, 32'd3);
    endtask

    // R7, R8 (and R9 when bump is set): staged release after qualified wake
    task automatic t_wake(input bit bump);
        logic [W-1:0] exp_d = data_q;
        logic         exp_o = oe_q;
        logic         exp_c = ce_q;
        logic [3:0]   ef;
        pd_pin = 1'b0;
        for (int n = 1; n <= LMIN + DOUT + 3; n++) begin
            if (bump) pd_pin = (n > LMIN + DIN) && (n <= LMIN + DIN + 3);
            data_in = W'(n * 37 + 5); oe_in = n[0]; ce_in = n[1];
            @(negedge clk);
            if (n - 1 >= LMIN + DIN)  exp_d = W'(n * 37 + 5);
            if (n - 1 >= LMIN + DOE)  exp_o = n[0];
            if (n - 1 >= LMIN + DCLK) exp_c = n[1];
            ef = {n >= LMIN + DOUT, n >= LMIN + DCLK, n >= LMIN + DOE, n >= LMIN + DIN};
            chk_flags(bump ? "R9" : "R7", ef);
            chk(bump ? "R9" : "R8", "data_q", {24'd0, data_q}, {24'd0, exp_d});
            chk("R8", "oe_q", {31'd0, oe_q}, {31'd0, exp_o});
            chk("R8", "ce_q", {31'd0, ce_q}, {31'd0, exp_c});
        end
        pd_pin = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_track();
        t_short_high();
        t_enter();
        t_short_low();
        t_wake(1'b0);
        t_track();
        t_enter();
        t_wake(1'b1);
        t_track();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule